// File: doc/BRIEF.md
# Machine Status Register Write-Legalization Unit

This block holds the machine-level status word of a processor hart and legalizes every software write to it. Each write passes through a per-field mask. The previous-privilege field and the address-translation mode field are accepted only when the written code is legal; otherwise each keeps its old contents. A summary dirty bit is recomputed at the top bit of the word after every write.

A restricted supervisor view of the same word is provided, along with delegation-filtered supervisor views of the interrupt-pending and interrupt-enable words. When a write alters any state that governs address translation, the block emits a one-cycle request to flush the translation cache.

Software reaches all six views through one write port (select, data) and one combinational read port (select, data). Reads always show the stored contents, so a read in the same cycle as a write returns the value from before the write.

Top module: `stat_csr_unit`

## Requirements
- R1: After reset, every view reads zero and `tlb_flush` is low.
- R2: A write to the machine status view (select 0) replaces only the writable fields. Their bit positions are SIE bit 0, MIE bit 1, SPIE bit 2, MPIE bit 3, SPP bit 4, FS bits 8:7, MPRV bit 11 and PUM bit 12. XS (bits 10:9) is also writable when `HAS_EXT` is 1.
- R3: MPP (bits 6:5) takes the written code only if that code is 0 (user), 1 (supervisor) or 3 (machine). A written code of 2 leaves MPP unchanged.
- R4: VM (bits 16:13) takes the written code only if it is legal. Code 0 (bare) is always legal. With XLEN 64, codes 2 and 3 are also legal. With XLEN 32, code 1 is also legal. Any other code leaves VM unchanged.
- R5: Bit XLEN-1 (the summary dirty bit) reads 1 exactly when FS equals 3 or XS equals 3.
- R6: `tlb_flush` is high for one cycle, in the cycle after a write whose stored result differs from the old value in VM, MPP, MPRV or PUM. It is low otherwise.
- R7: A read of the supervisor status view (select 1) returns only SIE, SPIE, SPP, FS, XS and PUM, plus the summary dirty bit at bit XLEN-1.
- R8: A write to the supervisor status view replaces only SIE, SPIE, SPP, FS, XS and PUM. All other machine fields keep their contents.
- R9: The machine pending (select 2) and enable (select 4) views read and write all IRQW bits. The supervisor pending (select 3) and enable (select 5) views read and write only the bits set in `irq_deleg`, and leave the other bits unchanged.
- R10: A read in the same cycle as a write returns the old value, and the new value is visible on the next cycle. Selects 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Target view of the write |
| wr_data | input | XLEN | Write data |
| irq_deleg | input | IRQW | Interrupt delegation mask |
| rd_sel | input | 3 | View to read |
| rd_data | output | XLEN | Read data of the selected view |
| tlb_flush | output | 1 | Translation-cache flush request |

## Verification
The assertions assume that `wr_sel`, `wr_en` and `irq_deleg` are settled before each rising edge. They also assume `irq_deleg` does not change in the cycle of a supervisor interrupt-view write. The bench drives all inputs on the falling edge and changes the delegation mask only in idle cycles. Under these conditions the checks for legal-field retention and merge preservation compare register contents across a single edge.

// File: rtl/stat_csr_pkg.sv
package stat_csr_pkg;
  // Field positions of the machine status word
  localparam int SIE_B  = 0;
  localparam int MIE_B  = 1;
  localparam int SPIE_B = 2;
  localparam int MPIE_B = 3;
  localparam int SPP_B  = 4;
  localparam int MPP_LO = 5;
  localparam int FS_LO  = 7;
  localparam int XS_LO  = 9;
  localparam int MPRV_B = 11;
  localparam int PUM_B  = 12;
  localparam int VM_LO  = 13;
  localparam int VM_W   = 4;

  // Masks
  localparam logic [31:0] M_BASE_MASK = 32'h0000_199F;
  localparam logic [31:0] XS_MASK     = 32'h0000_0600;
  localparam logic [31:0] MPP_MASK    = 32'h0000_0060;
  localparam logic [31:0] VM_MASK     = 32'h0001_E000;
  localparam logic [31:0] S_MASK      = 32'h0000_1795;
  localparam logic [31:0] XLATE_MASK  = VM_MASK | MPP_MASK | 32'h0000_1800;

  // Privilege codes
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  typedef enum logic [2:0] {
    SEL_MSTAT = 3'd0,
    SEL_SSTAT = 3'd1,
    SEL_MPEND = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_MEN   = 3'd4,
    SEL_SEN   = 3'd5
  } csr_sel_e;
endpackage

// File: rtl/stat_legalize.sv
module stat_legalize
  import stat_csr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [XLEN-1:0] cur_q,
  input  logic [XLEN-1:0] wdata,
  input  logic            sview,
  output logic [XLEN-1:0] nxt,
  output logic            xlate_chg
);
  localparam logic [XLEN-1:0] SM = XLEN'(S_MASK);
  localparam logic [XLEN-1:0] BASE =
    XLEN'(M_BASE_MASK) | (HAS_EXT ? XLEN'(XS_MASK) : '0);
  localparam logic [XLEN-1:0] SD_BIT = XLEN'(1) << (XLEN-1);

  logic [XLEN-1:0] merged, mask, body;
  logic [1:0]      mpp_w;
  logic [VM_W-1:0] vm_w;
  logic            mpp_ok, vm_ok;

  always_comb begin
    // supervisor writes merge through the narrower mask first
    merged = sview ? ((cur_q & ~SM) | (wdata & SM)) : wdata;
    mpp_w  = merged[MPP_LO +: 2];
    vm_w   = merged[VM_LO +: VM_W];
    mpp_ok = (mpp_w == PRV_U) || (mpp_w == PRV_S) || (mpp_w == PRV_M);
    if (XLEN == 64) vm_ok = (vm_w == 4'd0) || (vm_w == 4'd2) || (vm_w == 4'd3);
    else            vm_ok = (vm_w == 4'd0) || (vm_w == 4'd1);
    mask = BASE;
    if (mpp_ok) mask = mask | XLEN'(MPP_MASK);
    if (vm_ok)  mask = mask | XLEN'(VM_MASK);
    body = ((cur_q & ~mask) | (merged & mask)) & ~SD_BIT;
    nxt  = body;
    nxt[XLEN-1] = (body[FS_LO +: 2] == 2'b11) || (body[XS_LO +: 2] == 2'b11);
    xlate_chg = |((nxt ^ cur_q) & XLEN'(XLATE_MASK));
  end
endmodule

// File: rtl/intr_view.sv
module intr_view #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_m,
  input  logic         wr_s,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] deleg,
  output logic [W-1:0] m_rdata,
  output logic [W-1:0] s_rdata
);
  logic [W-1:0] vec_q, vec_d;
  logic         vec_en;

  always_comb begin
    vec_en = wr_m | wr_s;
    vec_d  = wr_m ? wdata : ((vec_q & ~deleg) | (wdata & deleg));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign m_rdata = vec_q;
  assign s_rdata = vec_q & deleg;

  // R9
  sview_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && !wr_m) |=> ((vec_q & ~$past(deleg)) == ($past(vec_q) & ~$past(deleg))));
endmodule

// File: rtl/stat_csr_unit.sv
module stat_csr_unit
  import stat_csr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IRQW    = 16,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IRQW-1:0] irq_deleg,
  input  logic [2:0]      rd_sel,
  output logic [XLEN-1:0] rd_data,
  output logic            tlb_flush
);
  localparam logic [XLEN-1:0] SM     = XLEN'(S_MASK);
  localparam logic [XLEN-1:0] SD_BIT = XLEN'(1) << (XLEN-1);
  localparam int NVIEW = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // status word
  logic [XLEN-1:0] mstat_q, mstat_d, leg_nxt;
  logic            leg_chg, stat_we, sview_w, flush_q, flush_d;

  assign stat_we = wr_en && ((wr_sel == SEL_MSTAT) || (wr_sel == SEL_SSTAT));
  assign sview_w = (wr_sel == SEL_SSTAT);

  stat_legalize #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) legal_i (
    .cur_q(mstat_q), .wdata(wr_data), .sview(sview_w),
    .nxt(leg_nxt), .xlate_chg(leg_chg)
  );

  always_comb begin
    mstat_d = leg_nxt;
    flush_d = stat_we && leg_chg;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mstat_q <= '0;
      flush_q <= 1'b0;
    end else begin
      if (stat_we) mstat_q <= mstat_d;
      flush_q <= flush_d;
    end
  end
  assign tlb_flush = flush_q;

  // interrupt pending / enable views
  logic [IRQW-1:0] m_rd [NVIEW];
  logic [IRQW-1:0] s_rd [NVIEW];
  for (genvar g = 0; g < NVIEW; g++) begin : g_iv
    localparam logic [2:0] MSEL = 3'(2 + 2*g);
    localparam logic [2:0] SSEL = 3'(3 + 2*g);
    intr_view #(.W(IRQW)) iv_i (
      .clk(clk), .rst_n(rst_int_n),
      .wr_m(wr_en && (wr_sel == MSEL)),
      .wr_s(wr_en && (wr_sel == SSEL)),
      .wdata(wr_data[IRQW-1:0]), .deleg(irq_deleg),
      .m_rdata(m_rd[g]), .s_rdata(s_rd[g])
    );
  end

  // read mux
  logic [XLEN-1:0] sstat_v;
  always_comb begin
    sstat_v = mstat_q & SM;
    sstat_v[XLEN-1] = (mstat_q[FS_LO +: 2] == 2'b11) || (mstat_q[XS_LO +: 2] == 2'b11);
    case (rd_sel)
      SEL_MSTAT: rd_data = mstat_q;
      SEL_SSTAT: rd_data = sstat_v;
      SEL_MPEND: rd_data = XLEN'(m_rd[0]);
      SEL_SPEND: rd_data = XLEN'(s_rd[0]);
      SEL_MEN:   rd_data = XLEN'(m_rd[1]);
      SEL_SEN:   rd_data = XLEN'(s_rd[1]);
      default:   rd_data = '0;
    endcase
  end

  // R3
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mstat_q[MPP_LO +: 2] != 2'd2);
  // R4
  vm_legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (XLEN == 64) ? (mstat_q[VM_LO +: VM_W] inside {4'd0, 4'd2, 4'd3})
                 : (mstat_q[VM_LO +: VM_W] inside {4'd0, 4'd1}));
  // R5
  sd_summary_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mstat_q[XLEN-1] == ((mstat_q[FS_LO +: 2] == 2'b11) || (mstat_q[XS_LO +: 2] == 2'b11)));
  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tlb_flush |-> $past(stat_we));
  // R8
  sview_merge_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_we && sview_w) |=> ((mstat_q & ~SM & ~SD_BIT) == ($past(mstat_q) & ~SM & ~SD_BIT)));
  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stat_we |=> $stable(mstat_q));
endmodule

// File: tb/stat_csr_unit_tb_top.sv
module stat_csr_unit_tb_top;
  localparam int XLEN = 64;
  localparam int IRQW = 16;
  localparam logic [63:0] SD = 64'h8000_0000_0000_0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_sel = 3'd0;
  logic [XLEN-1:0] wr_data = '0;
  logic [IRQW-1:0] irq_deleg = '0;
  logic [2:0]      rd_sel = 3'd0;
  logic [XLEN-1:0] rd_data;
  logic            tlb_flush;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stat_csr_unit #(.XLEN(XLEN), .IRQW(IRQW), .HAS_EXT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_deleg(irq_deleg), .rd_sel(rd_sel), .rd_data(rd_data), .tlb_flush(tlb_flush)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write, then check flush at the following falling edge
  task automatic wr(input logic [2:0] sel, input logic [63:0] d, input logic fl, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, {63'd0, tlb_flush}, {63'd0, fl});
  endtask

  task automatic rd(input logic [2:0] sel, input logic [63:0] exp, input string req);
    rd_sel = sel; #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) rd(3'(s), 64'd0, "R1 reset view");
    check("R1 flush", {63'd0, tlb_flush}, 64'd0);
  endtask

  task automatic t_mask;
    wr(3'd0, '1, 1'b1, "R6 flush on all-ones");
    rd(3'd0, SD | 64'h1FFF, "R2 R4 R5 all-ones write");
    @(negedge clk); check("R6 pulse single", {63'd0, tlb_flush}, 64'd0);
    wr(3'd0, 64'd0, 1'b1, "R6 flush on clear");
    rd(3'd0, 64'd0, "R2 clear");
  endtask

  task automatic t_mpp;
    wr(3'd0, 64'h20, 1'b1, "R6 flush MPP change");
    rd(3'd0, 64'h20, "R3 MPP=S");
    wr(3'd0, 64'h40, 1'b0, "R6 no flush illegal MPP");
    rd(3'd0, 64'h20, "R3 illegal MPP kept");
    wr(3'd0, 64'h0, 1'b1, "R6 flush MPP back");
  endtask

  task automatic t_vm;
    wr(3'd0, 64'h4000, 1'b1, "R6 flush VM set");
    rd(3'd0, 64'h4000, "R4 VM=2 legal");
    wr(3'd0, 64'h2000, 1'b0, "R6 no flush illegal VM");
    rd(3'd0, 64'h4000, "R4 VM=1 rejected");
    wr(3'd0, 64'h1E000, 1'b0, "R6 no flush VM=15");
    rd(3'd0, 64'h4000, "R4 VM=15 rejected");
    wr(3'd0, 64'h6000, 1'b1, "R6 flush VM=3");
    rd(3'd0, 64'h6000, "R4 VM=3 legal");
    wr(3'd0, 64'h0, 1'b1, "R6 flush VM bare");
  endtask

  task automatic t_sd;
    wr(3'd0, 64'h600, 1'b0, "R6 no flush XS");
    rd(3'd0, SD | 64'h600, "R5 SD via XS");
    wr(3'd0, 64'h80, 1'b0, "R6 no flush FS");
    rd(3'd0, 64'h80, "R5 no SD FS=1");
    wr(3'd0, 64'h3, 1'b0, "R6 no flush IE bits");
    rd(3'd0, 64'h3, "R2 SIE MIE");
  endtask

  task automatic t_sview;
    wr(3'd0, '1, 1'b1, "R6 flush set");
    wr(3'd1, 64'd0, 1'b1, "R6 flush PUM via S");
    rd(3'd0, 64'h86A, "R8 S clear keeps M fields");
    rd(3'd1, 64'h0, "R7 S view cleared");
    wr(3'd1, '1, 1'b1, "R6 flush PUM set via S");
    rd(3'd1, SD | 64'h1795, "R7 S view full");
    rd(3'd0, SD | 64'h1FFF, "R8 S write merge");
  endtask

  task automatic t_intr;
    @(negedge clk); irq_deleg = 16'h00F0;
    wr(3'd2, 64'hFFFF, 1'b0, "R9 no flush");
    rd(3'd2, 64'hFFFF, "R9 M pend");
    rd(3'd3, 64'h00F0, "R9 S pend filtered");
    wr(3'd3, 64'h0, 1'b0, "R9 no flush");
    rd(3'd2, 64'hFF0F, "R9 S pend write kept others");
    wr(3'd5, 64'hFFFF, 1'b0, "R9 no flush");
    rd(3'd4, 64'h00F0, "R9 S en delegated only");
    rd(3'd5, 64'h00F0, "R9 S en read");
  endtask

  task automatic t_rw;
    rd_sel = 3'd0;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 64'h1; #1;
    check("R10 same-cycle old", rd_data, SD | 64'h1FFF);
    @(negedge clk); wr_en = 1'b0; #1;
    check("R10 new next cycle", rd_data, 64'h1);
    wr(3'd7, '1, 1'b0, "R10 no flush sel 7");
    rd(3'd0, 64'h1, "R10 sel 7 write ignored");
    rd(3'd6, 64'h0, "R10 sel 6 reads zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset; t_mask; t_mpp; t_vm; t_sd; t_sview; t_intr; t_rw;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule